// File: doc/BRIEF.md
# DDR3 On-Die Termination Selector

This block lives inside a DDR3 device model. Every clock cycle it decides which on-die termination value, if any, is applied to the data-group pins. It works from five inputs: the nominal termination field of mode register 1, the dynamic write-termination field, the external ODT pin, the device state (initialized, calibrated, in self refresh) and the read and write burst activity indicators.

The selection is resolved through a fixed priority and then held in a register. On top of that register, the live read-burst and device-not-ready conditions clear the output in the same cycle. As a result, termination is never presented while read data is on the bus or while the device is not ready.

ODT latency timing, analog resistance and the pin drivers are outside this block.

Top module: `odt_term_sel`

## Requirements
- R1: While `rst_ni` is low, `term_en_o` is 0 and `term_code_o` is 0.
- R2: `rtt_nom_i` is the MR1 field packed as {bit 9, bit 6, bit 2}. Its codes decode as follows: 001 → RZQ/4, 010 → RZQ/2, 011 → RZQ/6, 100 → RZQ/12, 101 → RZQ/8, 000 → disabled.
- R3: In any cycle where `rd_burst_i` is high, `term_en_o` is 0 and `term_code_o` is 0, whatever the other inputs are.
- R4: Termination is 0 in any cycle where `init_done_i` is low, `calib_done_i` is low or `self_refresh_i` is high. This check ranks above all others.
- R5: When the device is ready, no read is active, `wr_burst_i` and `odt_i` are high, and `rtt_wr_i` is 01 (RZQ/4) or 10 (RZQ/2), the write value replaces the nominal value. This holds even when the nominal value is disabled.
- R6: During a write where `rtt_wr_i` is 00 or the reserved 11, the nominal value is selected as if no write were active.
- R7: With `odt_i` low, termination is off, including during a write.
- R8: The reserved nominal codes 110 and 111 behave as disabled.
- R9: Output encoding: 0 = off, 1 = RZQ/2, 2 = RZQ/4, 3 = RZQ/6, 4 = RZQ/8, 5 = RZQ/12. `term_en_o` is high exactly when `term_code_o` is not 0.
- R10: The output is the registered selection for the inputs sampled at the latest rising edge. In the cycle after a write ends with `odt_i` still high, the output returns to the nominal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtt_nom_i | input | 3 | Nominal termination field {bit9, bit6, bit2} |
| rtt_wr_i | input | 2 | Dynamic write termination field |
| odt_i | input | 1 | External ODT pin |
| init_done_i | input | 1 | Device initialization complete |
| calib_done_i | input | 1 | Device calibration complete |
| self_refresh_i | input | 1 | Device in self refresh |
| rd_burst_i | input | 1 | Read burst active |
| wr_burst_i | input | 1 | Write burst active |
| term_en_o | output | 1 | Termination applied |
| term_code_o | output | 3 | Selected termination value |

## Verification
The directed cases target these situations:
- A read that starts in the same cycle a write with dynamic termination is selected. A design that masks only through the register would leak termination for one cycle.
- The reserved nominal and write codes. A design that decoded them as real values would enable termination.
- Write termination with the nominal value disabled. Gating on the nominal field would wrongly turn termination off here.
- The cycle after a write ends. A design with a stale hold would keep the write value.

Seeded random stimulus then covers the mix of device-state flags against a priority model.

// File: rtl/odt_sel_pkg.sv
package odt_sel_pkg;
  localparam int NOM_W  = 3;
  localparam int WR_W   = 2;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    TERM_OFF   = 3'd0,
    TERM_RZQ2  = 3'd1,
    TERM_RZQ4  = 3'd2,
    TERM_RZQ6  = 3'd3,
    TERM_RZQ8  = 3'd4,
    TERM_RZQ12 = 3'd5
  } term_code_e;
endpackage

// File: rtl/odt_nom_decode.sv
module odt_nom_decode
  import odt_sel_pkg::*;
(
  input  logic [NOM_W-1:0] nom_i,
  output term_code_e       code_o
);
  // field order {mr1[9], mr1[6], mr1[2]}; reserved codes map to off
  always_comb begin
    unique case (nom_i)
      3'b001:  code_o = TERM_RZQ4;
      3'b010:  code_o = TERM_RZQ2;
      3'b011:  code_o = TERM_RZQ6;
      3'b100:  code_o = TERM_RZQ12;
      3'b101:  code_o = TERM_RZQ8;
      default: code_o = TERM_OFF;
    endcase
  end
endmodule

// File: rtl/odt_wr_decode.sv
module odt_wr_decode
  import odt_sel_pkg::*;
(
  input  logic [WR_W-1:0] wr_i,
  output term_code_e      code_o,
  output logic            en_o
);
  always_comb begin
    unique case (wr_i)
      2'b01:   code_o = TERM_RZQ4;
      2'b10:   code_o = TERM_RZQ2;
      default: code_o = TERM_OFF;
    endcase
    en_o = (code_o != TERM_OFF);
  end
endmodule

// File: rtl/odt_prio_sel.sv
module odt_prio_sel
  import odt_sel_pkg::*;
(
  input  logic       ready_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       odt_i,
  input  logic       dyn_en_i,
  input  term_code_e wr_code_i,
  input  term_code_e nom_code_i,
  output term_code_e code_o
);
  always_comb begin
    if (!ready_i)                   code_o = TERM_OFF;
    else if (rd_i)                  code_o = TERM_OFF;
    else if (!odt_i)                code_o = TERM_OFF;
    else if (wr_i && dyn_en_i)      code_o = wr_code_i;
    else                            code_o = nom_code_i;
  end
endmodule

// File: rtl/odt_term_sel.sv
module odt_term_sel
  import odt_sel_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NOM_W-1:0]  rtt_nom_i,
  input  logic [WR_W-1:0]   rtt_wr_i,
  input  logic              odt_i,
  input  logic              init_done_i,
  input  logic              calib_done_i,
  input  logic              self_refresh_i,
  input  logic              rd_burst_i,
  input  logic              wr_burst_i,
  output logic              term_en_o,
  output logic [CODE_W-1:0] term_code_o
);
  logic       ready;
  logic       dyn_en;
  logic       kill;
  term_code_e nom_code, wr_code, sel_code, sel_q;

  assign ready = init_done_i & calib_done_i & ~self_refresh_i;

  odt_nom_decode u_nom (.nom_i(rtt_nom_i), .code_o(nom_code));
  odt_wr_decode  u_wr  (.wr_i(rtt_wr_i), .code_o(wr_code), .en_o(dyn_en));

  odt_prio_sel u_prio (
    .ready_i   (ready),
    .rd_i      (rd_burst_i),
    .wr_i      (wr_burst_i),
    .odt_i     (odt_i),
    .dyn_en_i  (dyn_en),
    .wr_code_i (wr_code),
    .nom_code_i(nom_code),
    .code_o    (sel_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= TERM_OFF;
    else         sel_q <= sel_code;
  end

  // live kill so a read or a state drop never sees a stale registered value
  assign kill        = rd_burst_i | ~ready;
  assign term_code_o = kill ? CODE_W'(TERM_OFF) : sel_q;
  assign term_en_o   = (term_code_o != CODE_W'(TERM_OFF));

  p_rd_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_burst_i |-> !term_en_o);

  p_not_ready_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_i || !calib_done_i || self_refresh_i) |-> (term_code_o == '0));

  p_odt_low_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !odt_i |=> (sel_q == TERM_OFF));

  p_dyn_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !rd_burst_i && odt_i && wr_burst_i && rtt_wr_i == 2'b10)
      |=> (sel_q == TERM_RZQ2));

  p_reserved_nom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_burst_i && rtt_nom_i[2:1] == 2'b11) |=> (sel_q == TERM_OFF));
endmodule

// File: tb/odt_term_sel_test.sv
module odt_term_sel_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] rtt_nom_i = '0;
  logic [1:0] rtt_wr_i = '0;
  logic       odt_i = 1'b0, init_done_i = 1'b0, calib_done_i = 1'b0;
  logic       self_refresh_i = 1'b0, rd_burst_i = 1'b0, wr_burst_i = 1'b0;
  logic       term_en_o;
  logic [2:0] term_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  odt_term_sel uut (.*);

  function automatic logic [2:0] nom_map(input logic [2:0] n);
    case (n)
      3'b001: return 3'd2;
      3'b010: return 3'd1;
      3'b011: return 3'd3;
      3'b100: return 3'd5;
      3'b101: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] wr_map(input logic [1:0] w);
    case (w)
      2'b01: return 3'd2;
      2'b10: return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] model();
    if (!init_done_i || !calib_done_i || self_refresh_i) return 3'd0;
    if (rd_burst_i) return 3'd0;
    if (!odt_i) return 3'd0;
    if (wr_burst_i && wr_map(rtt_wr_i) != 3'd0) return wr_map(rtt_wr_i);
    return nom_map(rtt_nom_i);
  endfunction

  function automatic string req_tag();
    if (!init_done_i || !calib_done_i || self_refresh_i) return "R4";
    if (rd_burst_i) return "R3";
    if (!odt_i) return "R7";
    if (wr_burst_i && wr_map(rtt_wr_i) != 3'd0) return "R5";
    if (wr_burst_i) return "R6";
    if (rtt_nom_i[2:1] == 2'b11) return "R8";
    return "R2";
  endfunction

  task automatic check(input string req, input logic [2:0] exp);
    checks++;
    if (term_code_o !== exp || term_en_o !== (exp != 3'd0)) begin
      errors++;
      $display("FAIL %s: code=%0d en=%0b expected code=%0d en=%0b",
               req, term_code_o, term_en_o, exp, exp != 3'd0);
    end
  endtask

  task automatic set_in(input logic [2:0] nom, input logic [1:0] wr, input logic odt,
                        input logic ini, input logic cal, input logic sr,
                        input logic rd, input logic wb);
    @(negedge clk_i);
    rtt_nom_i = nom; rtt_wr_i = wr; odt_i = odt; init_done_i = ini;
    calib_done_i = cal; self_refresh_i = sr; rd_burst_i = rd; wr_burst_i = wb;
    @(posedge clk_i); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset holds outputs off even with all enables set
    rtt_nom_i = 3'b010; odt_i = 1'b1; init_done_i = 1'b1; calib_done_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #1 check("R1", 3'd0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R2/R9: each nominal code with odt high
    for (int n = 0; n < 8; n++) begin
      set_in(3'(n), 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check((n >= 6) ? "R8" : "R2_R9", nom_map(3'(n)));
    end
    // R4: each not-ready reason
    set_in(3'b001, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); check("R4", 3'd0);
    set_in(3'b001, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1); check("R4", 3'd0);
    set_in(3'b001, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); check("R4", 3'd0);
    // R5: write value with nominal disabled, then RZQ/2
    set_in(3'b000, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R5", 3'd2);
    set_in(3'b011, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R5", 3'd1);
    // R3: read rises while dynamic write selected: off in that same cycle
    @(negedge clk_i) rd_burst_i = 1'b1;
    #1 check("R3", 3'd0);
    @(posedge clk_i); #1 check("R3", 3'd0);
    // R10: write ends, odt still high -> nominal next cycle
    set_in(3'b011, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R5", 3'd1);
    set_in(3'b011, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0); check("R10", 3'd3);
    // R6: reserved and disabled write codes fall back to nominal
    set_in(3'b101, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R6", 3'd4);
    set_in(3'b100, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R6", 3'd5);
    // R7: odt low during write
    set_in(3'b100, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R7", 3'd0);
    // R8: reserved nominal during write without dynamic value
    set_in(3'b111, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1); check("R8", 3'd0);

    // random mix, readiness biased high
    for (int i = 0; i < 3000; i++) begin
      set_in(3'($urandom), 2'($urandom), 1'(($urandom % 4) != 0),
             1'(($urandom % 8) != 0), 1'(($urandom % 8) != 0),
             1'(($urandom % 8) == 0), 1'(($urandom % 4) == 0),
             1'(($urandom % 2) == 0));
      check(req_tag(), model());
      if (rd_burst_i && term_en_o) begin
        errors++;
        $display("FAIL R3: en=1 during read expected en=0");
      end
    end
    finish_run();
  end
endmodule